// File: doc/BRIEF.md
# Video Frame Signature Capture

This block computes a running CRC signature over the pixel stream of a video output, so that software can confirm that a displayed frame matches what was intended. The block watches the frame-sync line, the data-enable strobe and the 24-bit RGB pixel word. A capture is framed by the high-to-low transitions of the frame-sync line. It can cover exactly one frame, or it can run on without restarting across any number of frames. Everything runs in the pixel-clock domain.

Software drives a small control register and reads back a 32-bit signature. The control register has an enable bit and a free-run bit. It also has a read-only flag that rises once the signature is final. Two signature flavours exist, chosen by a mode input. One is a 32-bit CRC. The other is a 24-bit shift-register signature with a non-zero idle seed. While enable is low, the signature sits at the seed of the chosen flavour. Lowering enable is the only way to clear the completion flag and make ready for the next capture.

Top module: `vid_frame_sig`

## Requirements
- R1: `ctrl_rdata` presents enable at bit 0, free-run at bit 1 and the done flag at bit 2, with bits 63:3 always zero. It reads all zero after reset. A write with `ctrl_wr` high loads `ctrl_wdata[0]` into enable and `ctrl_wdata[1]` into free-run, visible on the next cycle.
- R2: While enable reads 0, `sig_rdata` is forced to 0x00000001 when `mode32` is 0, and to 0x00000000 when `mode32` is 1, one cycle after the condition. It is held there and pixels do not change it. The same seed applies during reset.
- R3: A falling frame-sync edge is a cycle in which `vsync` is low and was high in the previous cycle. Capture opens at the first such edge seen while enable already reads 1. An edge in the same cycle as the write that sets enable does not open a capture.
- R4: With free-run at 0, the capture closes at the next falling edge. From the following cycle the done flag reads 1 and `sig_rdata` no longer changes while enable stays 1.
- R5: During an open capture, only cycles with `de` high that are not a falling-edge cycle fold `pix` into the signature. Bits are folded in from bit 23 down to bit 0. For each bit, `fb` is the top signature bit XOR the data bit, the signature shifts left by one, and it is XORed with the polynomial when `fb` is 1. Wide mode uses a 32-bit register with polynomial 0x04C11DB7. Narrow mode uses a 24-bit register with polynomial 0x5D6DCB, and bits 31:24 of `sig_rdata` read 0. No reflection and no final inversion are applied.
- R6: With free-run at 1, falling edges do not close or restart the capture. The signature keeps accumulating and the done flag stays 0.
- R7: Clearing free-run during a free-running capture closes it at the next falling edge. The done flag then rises and the signature freezes.
- R8: One cycle after enable reads 0, the done flag reads 0 and the signature is back at the seed of R2.
- R9: `mode32` is sampled only while enable reads 0. A change while enable reads 1 does not affect the seed or the algorithm until enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vsync | input | 1 | Frame-sync line; falling edges delimit frames |
| de | input | 1 | Data-enable; pixel word is valid when high |
| pix | input | 24 | RGB pixel word |
| mode32 | input | 1 | 1 selects the 32-bit CRC, 0 the 24-bit signature |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 2 | Writable control bits: [0] enable, [1] free-run |
| ctrl_rdata | output | 64 | Control register readback |
| sig_rdata | output | 32 | Current signature |

## Verification
Two events can land in the same cycle: the control write that raises enable and a falling frame-sync edge. The bench provokes this by dropping `vsync` on the same cycle as the enable write. It then sends a partial frame, which must leave the signature at its seed and the done flag low. The next full frame must then produce exactly the expected signature. A second such coincidence, a pixel presented on a closing-edge cycle, is kept apart by holding `de` low on every edge cycle. The free-run-clear scenario then checks that closing waits for the next edge after the write.

// File: rtl/vfs_pkg.sv
// Package: shared widths, polynomials, capture states and the
// per-word signature step functions for the frame signature block.
// Assumes pixel words are folded MSB first, with no reflection.
package vfs_pkg;

    localparam int PIX_W    = 24;
    localparam int WIDE_W   = 32;
    localparam int NARROW_W = 24;
    localparam int CTRL_W   = 64;

    localparam logic [WIDE_W-1:0]   WIDE_POLY   = 32'h04C1_1DB7;
    localparam logic [NARROW_W-1:0] NARROW_POLY = 24'h5D_6DCB;

    localparam logic [WIDE_W-1:0] WIDE_SEED   = '0;
    localparam logic [WIDE_W-1:0] NARROW_SEED = WIDE_W'(1);

    typedef enum logic [1:0] {
        CAP_ARM  = 2'd0,
        CAP_RUN  = 2'd1,
        CAP_DONE = 2'd2
    } cap_state_e;

    // Fold one pixel word into the 32-bit CRC state.
    function automatic logic [WIDE_W-1:0] fold_wide(
        input logic [WIDE_W-1:0] state,
        input logic [PIX_W-1:0]  word
    );
        logic [WIDE_W-1:0] s;
        logic              fb;
        s = state;
        for (int i = PIX_W - 1; i >= 0; i--) begin
            fb = s[WIDE_W-1] ^ word[i];
            s  = {s[WIDE_W-2:0], 1'b0} ^ (fb ? WIDE_POLY : '0);
        end
        return s;
    endfunction

    // Fold one pixel word into the 24-bit shift-register signature.
    function automatic logic [NARROW_W-1:0] fold_narrow(
        input logic [NARROW_W-1:0] state,
        input logic [PIX_W-1:0]    word
    );
        logic [NARROW_W-1:0] s;
        logic                fb;
        s = state;
        for (int i = PIX_W - 1; i >= 0; i--) begin
            fb = s[NARROW_W-1] ^ word[i];
            s  = {s[NARROW_W-2:0], 1'b0} ^ (fb ? NARROW_POLY : '0);
        end
        return s;
    endfunction

endpackage

// File: rtl/vfs_sync_edge.sv
// Frame-sync edge detector: registers vsync once and flags a cycle
// where the line is low now but was high on the previous clock.
// Assumes vsync is already synchronous to clk.
module vfs_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic fall
);

    logic vsync_q;

    // Keep the previous frame-sync sample.
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync;
    end

    assign fall = vsync_q & ~vsync;

endmodule

// File: rtl/vfs_ctrl.sv
// Capture controller: holds the enable and free-run bits, latches the
// mode while idle and sequences arm / run / done on frame-sync edges.
// Assumes fall is a one-cycle pulse from vfs_sync_edge.
module vfs_ctrl
    import vfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_en,
    input  logic wr_fr,
    input  logic fall,
    input  logic de,
    input  logic mode32,
    output logic en_q,
    output logic fr_q,
    output logic done,
    output logic mode_q,
    output logic seed_load,
    output logic step
);

    cap_state_e st;

    // Software-writable enable and free-run bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            fr_q <= 1'b0;
        end else if (wr) begin
            en_q <= wr_en;
            fr_q <= wr_fr;
        end
    end

    // Track the mode only while capture is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) mode_q <= mode32;
    end

    // Capture sequencer driven by frame-sync falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) begin
            st <= CAP_ARM;
        end else begin
            unique case (st)
                CAP_ARM:  if (fall) st <= CAP_RUN;
                CAP_RUN:  if (fall && !fr_q) st <= CAP_DONE;
                CAP_DONE: st <= CAP_DONE;
                default:  st <= CAP_ARM;
            endcase
        end
    end

    assign done      = (st == CAP_DONE);
    assign seed_load = ~en_q;
    assign step      = (st == CAP_RUN) && en_q && de && !fall;

    // R8: dropping enable clears the done flag one cycle later.
    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !done);

    // R3: a capture only opens on an edge seen while enabled and armed.
    p_open_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_RUN && $past(st) == CAP_ARM) |-> $past(fall && en_q));

    // R4: done rises only at an edge with free-run off.
    p_done_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(fall && !fr_q && st == CAP_RUN));

    // R6: free-running capture survives a frame-sync edge.
    p_freerun_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_RUN && fall && fr_q && en_q && !wr) |=> st == CAP_RUN);

endmodule

// File: rtl/vfs_engine.sv
// Signature engine: one 32-bit register that is either seeded, held,
// or stepped by the wide CRC or the narrow shift-register fold.
// Assumes seed_mode is the live mode input and step_mode is latched.
module vfs_engine
    import vfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic              seed_mode,
    input  logic              step,
    input  logic              step_mode,
    input  logic [PIX_W-1:0]  pix,
    output logic [WIDE_W-1:0] sig
);

    localparam int PAD_W = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0] next_fold;

    // Pick the fold variant selected by the latched mode.
    always_comb begin
        if (step_mode) next_fold = fold_wide(sig, pix);
        else           next_fold = {{PAD_W{1'b0}}, fold_narrow(sig[NARROW_W-1:0], pix)};
    end

    // Seed while idle or in reset, otherwise step on accepted pixels.
    always_ff @(posedge clk) begin
        if (!rst_n || seed_load) sig <= seed_mode ? WIDE_SEED : NARROW_SEED;
        else if (step)           sig <= next_fold;
    end

    // R2: after a seed cycle the value matches the mode just latched.
    p_seed_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (sig == (step_mode ? WIDE_SEED : NARROW_SEED)));

    // R4: without a step request the signature does not move.
    p_hold_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !seed_load) |=> $stable(sig));

endmodule

// File: rtl/vid_frame_sig.sv
// Top level of the frame signature block: edge detector, capture
// controller and signature engine, plus the control readback word.
// Assumes every input is synchronous to the pixel clock.
module vid_frame_sig
    import vfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              de,
    input  logic [PIX_W-1:0]  pix,
    input  logic              mode32,
    input  logic              ctrl_wr,
    input  logic [1:0]        ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [WIDE_W-1:0] sig_rdata
);

    logic fall;
    logic en_q;
    logic fr_q;
    logic done;
    logic mode_q;
    logic seed_load;
    logic step;

    vfs_sync_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .vsync (vsync),
        .fall  (fall)
    );

    vfs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctrl_wr),
        .wr_en     (ctrl_wdata[0]),
        .wr_fr     (ctrl_wdata[1]),
        .fall      (fall),
        .de        (de),
        .mode32    (mode32),
        .en_q      (en_q),
        .fr_q      (fr_q),
        .done      (done),
        .mode_q    (mode_q),
        .seed_load (seed_load),
        .step      (step)
    );

    vfs_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_mode (mode32),
        .step      (step),
        .step_mode (mode_q),
        .pix       (pix),
        .sig       (sig_rdata)
    );

    // Control readback: reserved bits are tied low.
    assign ctrl_rdata = {{(CTRL_W-3){1'b0}}, done, fr_q, en_q};

    // R5: in narrow mode the top byte of the signature stays clear.
    p_narrow_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (sig_rdata[WIDE_W-1:NARROW_W] == '0));

    // R4: once done and still enabled, the readout is frozen.
    p_frozen_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en_q) |=> $stable(sig_rdata));

endmodule

// File: tb/vid_frame_sig_test.sv
module vid_frame_sig_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        vsync;
    logic        de;
    logic [23:0] pix;
    logic        mode32;
    logic        ctrl_wr;
    logic [1:0]  ctrl_wdata;
    logic [63:0] ctrl_rdata;
    logic [31:0] sig_rdata;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] exp_sig;
    bit          mdl_on   = 1'b0;
    bit          mdl_wide = 1'b0;
    logic [23:0] pgen     = 24'hA5_1C3E;

    vid_frame_sig uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync      (vsync),
        .de         (de),
        .pix        (pix),
        .mode32     (mode32),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .sig_rdata  (sig_rdata)
    );

    always #10 clk = ~clk;

    // Bit-serial reference of the R5 fold rule.
    function automatic logic [31:0] ref_fold(input logic [31:0] acc,
                                             input logic [23:0] d,
                                             input bit wide);
        logic [31:0] a;
        logic        top;
        a = acc;
        for (int k = 23; k >= 0; k--) begin
            if (wide) begin
                top = a[31];
                a   = a << 1;
                if (top ^ d[k]) a = a ^ 32'h04C11DB7;
            end else begin
                top = a[23];
                a   = {8'h00, a[22:0], 1'b0};
                if (top ^ d[k]) a = a ^ 32'h005D6DCB;
            end
        end
        return a;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr_ctrl(input bit en, input bit fr);
        ctrl_wr    = 1'b1;
        ctrl_wdata = {fr, en};
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic idle(input int n);
        de = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic vs_fall();
        de    = 1'b0;
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
    endtask

    // Send n pixels, with a blanking cycle carrying junk after every third.
    task automatic pixels(input int n);
        for (int i = 0; i < n; i++) begin
            pgen = {pgen[22:0], pgen[23] ^ pgen[22] ^ pgen[21] ^ pgen[16]};
            pix  = pgen;
            de   = 1'b1;
            if (mdl_on) exp_sig = ref_fold(exp_sig, pgen, mdl_wide);
            @(negedge clk);
            if (i % 3 == 2) begin
                de  = 1'b0;
                pix = ~pgen;
                @(negedge clk);
            end
        end
        de = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset control word", ctrl_rdata, 64'h0);
        chk("R2 reset seed narrow", {32'h0, sig_rdata}, 64'h1);
    endtask

    task automatic t_seeds();
        mode32 = 1'b1;
        idle(2);
        chk("R2 idle seed wide", {32'h0, sig_rdata}, 64'h0);
        mode32 = 1'b0;
        idle(2);
        chk("R2 idle seed narrow", {32'h0, sig_rdata}, 64'h1);
        vs_fall();
        pixels(5);
        vs_fall();
        chk("R2 no accumulation while disabled", {32'h0, sig_rdata}, 64'h1);
    endtask

    task automatic t_ctrl_bits();
        wr_ctrl(1'b0, 1'b1);
        chk("R1 free-run bit readback", ctrl_rdata, 64'h2);
        wr_ctrl(1'b0, 1'b0);
        chk("R1 cleared readback", ctrl_rdata, 64'h0);
    endtask

    task automatic t_single(input bit wide);
        logic [31:0] seed;
        seed   = wide ? 32'h0 : 32'h1;
        mode32 = wide;
        idle(2);
        wr_ctrl(1'b1, 1'b0);
        chk("R1 enable readback", ctrl_rdata, 64'h1);
        pixels(3);
        chk("R3 no capture before edge", {32'h0, sig_rdata}, {32'h0, seed});
        vs_fall();
        mdl_on   = 1'b1;
        mdl_wide = wide;
        exp_sig  = seed;
        pixels(10);
        mdl_on = 1'b0;
        vs_fall();
        chk("R4 done flag after single frame", ctrl_rdata, 64'h5);
        chk(wide ? "R5 wide CRC value" : "R5 narrow signature value",
            {32'h0, sig_rdata}, {32'h0, exp_sig});
        pixels(4);
        vs_fall();
        chk("R4 signature frozen after done", {32'h0, sig_rdata}, {32'h0, exp_sig});
        wr_ctrl(1'b0, 1'b0);
        idle(1);
        chk("R8 done cleared", ctrl_rdata, 64'h0);
        chk("R8 signature reseeded", {32'h0, sig_rdata}, {32'h0, seed});
    endtask

    task automatic t_same_cycle();
        mode32 = 1'b0;
        vsync  = 1'b1;
        idle(2);
        vsync      = 1'b0;
        ctrl_wr    = 1'b1;
        ctrl_wdata = 2'b01;
        @(negedge clk);
        ctrl_wr = 1'b0;
        pixels(5);
        chk("R3 edge in write cycle ignored flag", ctrl_rdata, 64'h1);
        chk("R3 edge in write cycle ignored sig", {32'h0, sig_rdata}, 64'h1);
        vs_fall();
        mdl_on   = 1'b1;
        mdl_wide = 1'b0;
        exp_sig  = 32'h1;
        pixels(6);
        mdl_on = 1'b0;
        vs_fall();
        chk("R3 later edge opens capture", ctrl_rdata, 64'h5);
        chk("R3 only the later frame signed", {32'h0, sig_rdata}, {32'h0, exp_sig});
        wr_ctrl(1'b0, 1'b0);
        idle(1);
    endtask

    task automatic t_freerun();
        mode32 = 1'b1;
        idle(2);
        wr_ctrl(1'b1, 1'b1);
        vs_fall();
        mdl_on   = 1'b1;
        mdl_wide = 1'b1;
        exp_sig  = 32'h0;
        pixels(8);
        vs_fall();
        pixels(8);
        chk("R6 no done in free-run", ctrl_rdata, 64'h3);
        chk("R6 accumulates across edge", {32'h0, sig_rdata}, {32'h0, exp_sig});
        vs_fall();
        pixels(4);
        wr_ctrl(1'b1, 1'b0);
        pixels(5);
        chk("R7 still open after free-run clear", ctrl_rdata, 64'h1);
        mdl_on = 1'b0;
        vs_fall();
        chk("R7 done at next edge", ctrl_rdata, 64'h5);
        chk("R7 signature of whole run", {32'h0, sig_rdata}, {32'h0, exp_sig});
        wr_ctrl(1'b0, 1'b0);
        idle(1);
    endtask

    task automatic t_mode_lock();
        mode32 = 1'b0;
        idle(2);
        wr_ctrl(1'b1, 1'b0);
        mode32 = 1'b1;
        idle(2);
        chk("R9 seed unchanged by mode while enabled", {32'h0, sig_rdata}, 64'h1);
        vs_fall();
        mdl_on   = 1'b1;
        mdl_wide = 1'b0;
        exp_sig  = 32'h1;
        pixels(7);
        mdl_on = 1'b0;
        vs_fall();
        chk("R9 latched narrow algorithm used", {32'h0, sig_rdata}, {32'h0, exp_sig});
        wr_ctrl(1'b0, 1'b0);
        idle(1);
        chk("R9 new mode taken after disable", {32'h0, sig_rdata}, 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        vsync      = 1'b0;
        de         = 1'b0;
        pix        = '0;
        mode32     = 1'b0;
        ctrl_wr    = 1'b0;
        ctrl_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seeds();
        t_ctrl_bits();
        t_single(1'b1);
        t_single(1'b0);
        t_same_cycle();
        t_freerun();
        t_mode_lock();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule